// File: doc/BRIEF.md
# Holdover Tuning Word Averager

This block sits beside a closed digital frequency-control loop and watches the frequency tuning words that the loop produces. It takes one sample out of every 2^P loop strobes and sums the samples over a window of 2^N of them. When a window is full, the sum is divided by 2^N and kept as the current average. The sum is then cleared, so each average covers one window of samples and windows do not overlap.

When the loop is opened for holdover, a single enter pulse freezes one word into a held register, and the oscillator keeps running from that word until holdover ends. A mode input picks which word is frozen. One choice is the word from the most recent loop strobe. The other is the latest completed average, which falls back to the most recent word while no window has yet completed.

Changing the window size or the prescale exponent starts the decimation and the window over from nothing.

Top module: `holdover_ftw_avg`

## Requirements
- R1: Reset state: `heldFtw` is zero and both `inHold` and `avgValid` are low.
- R2: Counted from the last reset or restart, every 2^P-th cycle with `loopStrobe` high takes a sample, where P is `preExp`. The other strobes only update the most recent word.
- R3: The average equals floor(sum of 2^N consecutive samples / 2^N), with N being `winSize` (0 to 15). Words of all ones at N = 15 average to all ones, so no overflow occurs.
- R4: `avgValid` rises in the cycle after the first window completes. It then stays high until reset.
- R5: With `avgMode` = 0, the captured word is `ftwIn` from the most recent strobe before the capture cycle.
- R6: With `avgMode` = 1, the captured word is the latest completed average. While `avgValid` is low it is the most recent strobed word instead.
- R7: A `holdEnter` pulse while `inHold` is low captures into `heldFtw` and raises `inHold` at the next edge. A strobe in that same cycle is not part of the captured value.
- R8: While `inHold` is high, `heldFtw` does not change. Further `holdEnter` pulses and further strobes are ignored.
- R9: `holdExit` while `inHold` is high drops `inHold` at the next edge. `heldFtw` keeps its value until the next capture.
- R10: A change in `winSize` or `preExp` restarts the prescaler and the window. Samples taken before the change are excluded from later averages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ftwIn | input | FTW_W | Tuning word from the loop |
| loopStrobe | input | 1 | Loop update strobe qualifying `ftwIn` |
| winSize | input | WIN_W | Window exponent N |
| preExp | input | PRE_W | Prescale exponent P |
| avgMode | input | 1 | 0: last word, 1: averaged word |
| holdEnter | input | 1 | Holdover entry pulse |
| holdExit | input | 1 | Holdover exit pulse |
| heldFtw | output | FTW_W | Frozen holdover tuning word |
| inHold | output | 1 | Holdover active |
| avgValid | output | 1 | At least one window has completed |

## Verification
The averaging path is driven with ramps that separate a block average from the last sample. A ramp of six words with a window of four distinguishes the completed average from a partial sum. Odd ramps expose the floor division. Words of all ones over the largest window reveal any truncation of the accumulator. Decimated streams show whether the strobes that are skipped are really excluded. A window that is left unfinished must return the last word with `avgValid` low. A configuration change made in the middle of a window must drop the earlier samples from the result.

// File: rtl/hold_avg_pkg.sv
package hold_avg_pkg;
  // Strobes passed from control to datapath, one cycle each.
  typedef struct packed {
    logic strobeSeen;   // loop strobe present, refresh last word
    logic restart;      // configuration changed, clear accumulator
    logic takeSample;   // decimated sample enters accumulator
    logic closeWindow;  // this sample completes the window
    logic captureHold;  // freeze the selected word
  } ctlStrobes_t;
endpackage

// File: rtl/hold_avg_ctrl.sv
module hold_avg_ctrl
  import hold_avg_pkg::*;
#(
  parameter int WIN_W = 4,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopStrobe,
  input  logic [WIN_W-1:0] winSize,
  input  logic [PRE_W-1:0] preExp,
  input  logic             holdEnter,
  input  logic             holdExit,
  output ctlStrobes_t      strb,
  output logic [WIN_W-1:0] shiftAmt,
  output logic             avgValid,
  output logic             inHold
);
  localparam int WCNT_W = (1 << WIN_W) - 1;
  localparam int PCNT_W = (1 << PRE_W) - 1;

  logic [WIN_W-1:0]  cfgWin;
  logic [PRE_W-1:0]  cfgPre;
  logic [WCNT_W-1:0] winCnt;
  logic [WCNT_W-1:0] winLast;
  logic [PCNT_W-1:0] preCnt;
  logic [PCNT_W-1:0] preMask;
  logic              cfgChange;
  logic              preHit;

  assign shiftAmt = cfgWin;

  always_comb begin
    winLast   = (WCNT_W'(1) << cfgWin) - WCNT_W'(1);
    preMask   = (PCNT_W'(1) << cfgPre) - PCNT_W'(1);
    cfgChange = (winSize != cfgWin) || (preExp != cfgPre);
    preHit    = (preCnt == preMask);
    strb.strobeSeen  = loopStrobe;
    strb.restart     = cfgChange;
    strb.takeSample  = loopStrobe && !cfgChange && preHit;
    strb.closeWindow = strb.takeSample && (winCnt == winLast);
    strb.captureHold = holdEnter && !inHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWin   <= '0;
      cfgPre   <= '0;
      preCnt   <= '0;
      winCnt   <= '0;
      avgValid <= 1'b0;
      inHold   <= 1'b0;
    end else begin
      if (cfgChange) begin
        cfgWin <= winSize;
        cfgPre <= preExp;
        preCnt <= '0;
        winCnt <= '0;
      end else if (loopStrobe) begin
        if (preHit) begin
          preCnt <= '0;
          if (strb.closeWindow) begin
            winCnt   <= '0;
            avgValid <= 1'b1;
          end else begin
            winCnt <= winCnt + WCNT_W'(1);
          end
        end else begin
          preCnt <= preCnt + PCNT_W'(1);
        end
      end
      if (strb.captureHold) inHold <= 1'b1;
      else if (holdExit)    inHold <= 1'b0;
    end
  end
endmodule

// File: rtl/hold_avg_dp.sv
module hold_avg_dp
  import hold_avg_pkg::*;
#(
  parameter int FTW_W = 32,
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [FTW_W-1:0] ftwIn,
  input  logic [WIN_W-1:0] shiftAmt,
  input  logic             avgMode,
  input  logic             avgValid,
  output logic [FTW_W-1:0] heldFtw,
  output logic [FTW_W-1:0] lastWord
);
  localparam int ACC_W = FTW_W + (1 << WIN_W) - 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [FTW_W-1:0] avgWord;
  logic [FTW_W-1:0] avgNext;
  logic [FTW_W-1:0] pickWord;

  always_comb begin
    accSum   = acc + ACC_W'(ftwIn);
    avgNext  = FTW_W'(accSum >> shiftAmt);
    pickWord = (avgMode && avgValid) ? avgWord : lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      avgWord  <= '0;
      lastWord <= '0;
      heldFtw  <= '0;
    end else begin
      if (strb.strobeSeen) lastWord <= ftwIn;
      if (strb.restart) begin
        acc <= '0;
      end else if (strb.takeSample) begin
        if (strb.closeWindow) begin
          acc     <= '0;
          avgWord <= avgNext;
        end else begin
          acc <= accSum;
        end
      end
      if (strb.captureHold) heldFtw <= pickWord;
    end
  end
endmodule

// File: rtl/holdover_ftw_avg.sv
module holdover_ftw_avg
  import hold_avg_pkg::*;
#(
  parameter int FTW_W = 32,
  parameter int WIN_W = 4,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FTW_W-1:0] ftwIn,
  input  logic             loopStrobe,
  input  logic [WIN_W-1:0] winSize,
  input  logic [PRE_W-1:0] preExp,
  input  logic             avgMode,
  input  logic             holdEnter,
  input  logic             holdExit,
  output logic [FTW_W-1:0] heldFtw,
  output logic             inHold,
  output logic             avgValid
);
  ctlStrobes_t      strb;
  logic [WIN_W-1:0] shiftAmt;
  logic [FTW_W-1:0] lastWord;

  hold_avg_ctrl #(.WIN_W(WIN_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loopStrobe(loopStrobe), .winSize(winSize),
    .preExp(preExp), .holdEnter(holdEnter), .holdExit(holdExit),
    .strb(strb), .shiftAmt(shiftAmt), .avgValid(avgValid), .inHold(inHold)
  );

  hold_avg_dp #(.FTW_W(FTW_W), .WIN_W(WIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ftwIn(ftwIn), .shiftAmt(shiftAmt),
    .avgMode(avgMode), .avgValid(avgValid), .heldFtw(heldFtw),
    .lastWord(lastWord)
  );
endmodule

// File: rtl/holdover_ftw_avg_chk.sv
module holdover_ftw_avg_chk #(
  parameter int FTW_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             holdEnter,
  input logic             holdExit,
  input logic             avgMode,
  input logic             inHold,
  input logic             avgValid,
  input logic [FTW_W-1:0] heldFtw,
  input logic [FTW_W-1:0] lastWord
);
  // R4: once set, avgValid only falls through reset
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |=> avgValid);

  // R7: entry pulse outside holdover raises inHold
  a_r7_enter_sets: assert property (@(posedge clk) disable iff (!rstN)
    (holdEnter && !inHold) |=> inHold);

  // R5: last-word mode freezes the word held before the entry edge
  a_r5_last_word: assert property (@(posedge clk) disable iff (!rstN)
    (holdEnter && !inHold && !avgMode) |=> (heldFtw == $past(lastWord)));

  // R8: held word does not move during holdover
  a_r8_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    (inHold && $past(inHold)) |-> $stable(heldFtw));

  // R9: exit pulse ends holdover
  a_r9_exit_clears: assert property (@(posedge clk) disable iff (!rstN)
    (inHold && holdExit) |=> !inHold);
endmodule

bind holdover_ftw_avg holdover_ftw_avg_chk #(.FTW_W(FTW_W)) u_chk (
  .clk(clk), .rstN(rstN), .holdEnter(holdEnter), .holdExit(holdExit),
  .avgMode(avgMode), .inHold(inHold), .avgValid(avgValid),
  .heldFtw(heldFtw), .lastWord(lastWord)
);

// File: tb/holdover_ftw_avg_bench.sv
`timescale 1ns/1ps
module holdover_ftw_avg_bench;
  localparam int FTW_W = 32;
  localparam int NV = 9;

  // Vector table: window, prescale, strobe count, ramp base/step, mode,
  // expected held word, expected avgValid.
  localparam logic [3:0]  V_WIN  [NV] = '{4'd2, 4'd2, 4'd2, 4'd2, 4'd0, 4'd3, 4'd2, 4'd2, 4'd1};
  localparam logic [3:0]  V_PRE  [NV] = '{4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2};
  localparam int          V_CNT  [NV] = '{4, 4, 8, 3, 1, 8, 6, 4, 8};
  localparam logic [31:0] V_BASE [NV] = '{32'd100, 32'd100, 32'd10, 32'd100, 32'd7, 32'd1, 32'd100, 32'hFFFF_FFFF, 32'd4};
  localparam logic [31:0] V_STEP [NV] = '{32'd100, 32'd100, 32'd10, 32'd100, 32'd0, 32'd1, 32'd100, 32'd0, 32'd4};
  localparam logic        V_MODE [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_EXP  [NV] = '{32'd250, 32'd400, 32'd50, 32'd300, 32'd7, 32'd4, 32'd250, 32'hFFFF_FFFF, 32'd24};
  localparam logic        V_VAL  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic             clk = 1'b0;
  logic             rstN;
  logic [FTW_W-1:0] ftwIn;
  logic             loopStrobe;
  logic [3:0]       winSize;
  logic [3:0]       preExp;
  logic             avgMode;
  logic             holdEnter;
  logic             holdExit;
  logic [FTW_W-1:0] heldFtw;
  logic             inHold;
  logic             avgValid;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  holdover_ftw_avg u_holdover_ftw_avg (
    .clk(clk), .rstN(rstN), .ftwIn(ftwIn), .loopStrobe(loopStrobe),
    .winSize(winSize), .preExp(preExp), .avgMode(avgMode),
    .holdEnter(holdEnter), .holdExit(holdExit), .heldFtw(heldFtw),
    .inHold(inHold), .avgValid(avgValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [3:0] w, input logic [3:0] p);
    @(negedge clk);
    rstN = 1'b0; loopStrobe = 1'b0; holdEnter = 1'b0; holdExit = 1'b0;
    ftwIn = '0; winSize = w; preExp = p;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic strobe(input logic [31:0] w);
    @(negedge clk);
    ftwIn = w; loopStrobe = 1'b1;
    @(negedge clk);
    loopStrobe = 1'b0;
  endtask

  task automatic enterHold();
    @(negedge clk);
    holdEnter = 1'b1;
    @(negedge clk);
    holdEnter = 1'b0;
  endtask

  task automatic exitHold();
    @(negedge clk);
    holdExit = 1'b1;
    @(negedge clk);
    holdExit = 1'b0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ftwIn = '0; loopStrobe = 1'b0; winSize = '0; preExp = '0;
    avgMode = 1'b0; holdEnter = 1'b0; holdExit = 1'b0;
    doReset(4'd0, 4'd0);
    @(negedge clk);
    // R1 reset state
    check("R1 heldFtw", heldFtw, 32'd0);
    check("R1 inHold", {31'd0, inHold}, 32'd0);
    check("R1 avgValid", {31'd0, avgValid}, 32'd0);

    // Table walk: R2 prescale, R3 window, R4 valid, R5/R6 mode select
    for (int i = 0; i < NV; i++) begin
      doReset(V_WIN[i], V_PRE[i]);
      avgMode = V_MODE[i];
      for (int k = 0; k < V_CNT[i]; k++) strobe(V_BASE[i] + V_STEP[i] * k);
      enterHold();
      check(V_MODE[i] ? "R6 R3 R2 held word" : "R5 held word", heldFtw, V_EXP[i]);
      check("R4 avgValid", {31'd0, avgValid}, {31'd0, V_VAL[i]});
      check("R7 inHold", {31'd0, inHold}, 32'd1);
    end

    // R8: strobes and a second entry pulse leave the held word alone
    doReset(4'd2, 4'd0);
    avgMode = 1'b1;
    for (int k = 0; k < 4; k++) strobe(32'd100 + 32'd100 * k);
    enterHold();
    for (int k = 0; k < 4; k++) strobe(32'd999);
    enterHold();
    check("R8 held after pulses", heldFtw, 32'd250);
    // R9: exit clears inHold, value stays
    exitHold();
    check("R9 inHold low", {31'd0, inHold}, 32'd0);
    check("R9 held kept", heldFtw, 32'd250);
    enterHold();
    check("R9 recapture", heldFtw, 32'd999);

    // R7: strobe in the capture cycle is not captured
    doReset(4'd0, 4'd0);
    avgMode = 1'b0;
    strobe(32'd11);
    @(negedge clk);
    ftwIn = 32'd22; loopStrobe = 1'b1; holdEnter = 1'b1;
    @(negedge clk);
    loopStrobe = 1'b0; holdEnter = 1'b0;
    check("R7 same-cycle strobe excluded", heldFtw, 32'd11);

    // R10: window change mid-window drops earlier samples
    doReset(4'd2, 4'd0);
    avgMode = 1'b1;
    strobe(32'd1000);
    strobe(32'd1000);
    @(negedge clk);
    winSize = 4'd1;
    strobe(32'd10);
    strobe(32'd30);
    enterHold();
    check("R10 restart window", heldFtw, 32'd20);

    // R3: largest window with all-ones words
    doReset(4'd15, 4'd0);
    avgMode = 1'b1;
    @(negedge clk);
    ftwIn = 32'hFFFF_FFFF; loopStrobe = 1'b1;
    for (int k = 0; k < 32767; k++) @(negedge clk);
    check("R4 valid low before last sample", {31'd0, avgValid}, 32'd0);
    @(negedge clk);
    loopStrobe = 1'b0;
    check("R4 valid after full window", {31'd0, avgValid}, 32'd1);
    ftwIn = '0;
    enterHold();
    check("R3 max window no overflow", heldFtw, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule